// File: doc/BRIEF.md
# Supervisory Reset Timing Controller

This block is the digital back end of a supply supervisor. Analog comparators elsewhere produce four flags: a supply-good flag, a low-line flag, a power-fail flag and a raw manual-reset level. The controller turns these into three active-low outputs. The first is a stretched system reset. The other two are an early low-line warning and a power-fail warning, and neither of them affects the reset.

All four inputs pass through two-flop synchronisers. The manual-reset input has a bounce filter. A low level must persist for longer than a qualification window before it counts. A qualified request then takes effect after a further fixed delay, and it does so even if the button has already been let go by then.

Reset is released only after every cause has been clear for one full time-out. Any renewed fault restarts that time-out from zero. All time values are given in microseconds and converted into clock cycles through a cycles-per-microsecond parameter. A test bench can therefore shrink them.

Top module: `sup_reset_ctrl`

In the text below:
- TO is TIMEOUT_US × CYC_PER_US.
- Q is MR_QUAL_US × CYC_PER_US.
- D is MR_DLY_US × CYC_PER_US, with D ≥ 1.
- Cycle counts are clock edges after an input change made between edges.

## Requirements
- R1: When `supply_ok` goes to 0, `rst_n` is 0 after the 3rd edge, and it stays 0 for as long as `supply_ok` remains 0.
- R2: When `supply_ok` returns to 1 with no manual request active, `rst_n` is still 0 after edge TO+2 and is 1 after edge TO+3.
- R3: A drop of `supply_ok` while the time-out is running keeps `rst_n` at 0. The time-out restarts, and release comes TO+3 edges after the last return of `supply_ok` to 1.
- R4: A low pulse on `mr_n` lasting at most Q cycles is ignored, and `rst_n` stays 1 throughout.
- R5: A low pulse on `mr_n` lasting more than Q cycles makes `rst_n` 0 after edge Q+D+4 and not before, even if `mr_n` has gone high in the meantime.
- R6: After a manual request, release follows one full time-out with the supply good. With `mr_n` held low past edge Q+D+3, `rst_n` is 1 exactly TO+4 edges after `mr_n` rises. For a shorter qualified pulse, `rst_n` is 1 after edge Q+D+5+TO.
- R7: `pfail_n` equals the inverse of `pfail_flag` with a latency of 3 edges, and `pfail_flag` has no effect on `rst_n`.
- R8: `lowline_n` equals the inverse of `lowline_flag` with a latency of 3 edges, and `lowline_flag` has no effect on `rst_n`.
- R9: While `test_rst` is 1, all three outputs are 0 and the timers are cleared. After `test_rst` falls with `supply_ok` at 1, `rst_n` is 0 after edge TO+2 and 1 after edge TO+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of CYC_PER_US cycles per microsecond |
| test_rst | input | 1 | Synchronous active-high test reset |
| supply_ok | input | 1 | 1 when the monitored supply is above the reset threshold |
| lowline_flag | input | 1 | 1 when the supply is below the early-warning level |
| pfail_flag | input | 1 | 1 when the second monitored input is below its threshold |
| mr_n | input | 1 | Raw manual-reset level, low means pressed |
| rst_n | output | 1 | Stretched system reset, active low |
| lowline_n | output | 1 | Low-line warning, active low |
| pfail_n | output | 1 | Power-fail warning, active low |

## Verification
Every path has a fixed latency:
- The two warning outputs follow their flags 3 edges later.
- A supply loss reaches `rst_n` after 3 edges.
- A qualified manual request reaches `rst_n` after Q+D+4 edges.
- Release comes TO+3 edges after the supply recovers, or TO+4 edges after `mr_n` rises.

The bench drives all inputs on the falling edge and counts exact rising edges from each change. For every boundary it checks the output both one edge before and at the edge where the change is due. Each manual-reset trial compares `rst_n` edge by edge against a computed low window. The same trials compare the warning outputs against a three-deep history of randomly driven flags.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // flag positions inside the synchroniser vector
  localparam int unsigned NFLAG  = 4;
  localparam int unsigned FL_SUP = 0;
  localparam int unsigned FL_LL  = 1;
  localparam int unsigned FL_PF  = 2;
  localparam int unsigned FL_MR  = 3;
  // safe values while in test reset: supply bad, warnings active, button released
  localparam logic [NFLAG-1:0] FLAG_RST = 4'b1110;

  function automatic int unsigned us2cyc(input int unsigned us, input int unsigned cpu);
    return us * cpu;
  endfunction

  function automatic int unsigned cwidth(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned     W       = 4,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         srst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (srst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/sup_mr_qual.sv
module sup_mr_qual
  import sup_pkg::*;
#(
  parameter int unsigned QUAL_CYC = 5000,
  parameter int unsigned DLY_CYC  = 2400
) (
  input  logic clk,
  input  logic srst,
  input  logic mr_s,      // synchronised, low = pressed
  output logic qual_hit,  // low level has outlasted the bounce window
  output logic fire,      // post-qualification delay just completed
  output logic mr_act     // manual request holding reset
);
  localparam int unsigned QW = cwidth(QUAL_CYC);
  localparam int unsigned DW = cwidth(DLY_CYC);
  localparam logic [QW-1:0] QUAL_V   = QW'(QUAL_CYC);
  localparam logic [DW-1:0] DLY_LAST = DW'(DLY_CYC - 1);

  logic [QW-1:0] qcnt;
  logic [DW-1:0] dcnt;
  logic          pend;

  // consecutive low samples, saturating at the window length
  always_ff @(posedge clk) begin
    if (srst || mr_s)       qcnt <= '0;
    else if (qcnt != QUAL_V) qcnt <= qcnt + 1'b1;
  end

  assign qual_hit = !mr_s && (qcnt == QUAL_V);
  assign fire     = pend && (dcnt == DLY_LAST);

  // delay runs to completion once started
  always_ff @(posedge clk) begin
    if (srst) begin
      pend <= 1'b0;
      dcnt <= '0;
    end else if (fire) begin
      pend <= 1'b0;
    end else if (pend) begin
      dcnt <= dcnt + 1'b1;
    end else if (qual_hit && !mr_act) begin
      pend <= 1'b1;
      dcnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (srst)      mr_act <= 1'b0;
    else if (fire) mr_act <= 1'b1;
    else if (mr_s) mr_act <= 1'b0;
  end
endmodule

// File: rtl/sup_rel_timer.sv
module sup_rel_timer
  import sup_pkg::*;
#(
  parameter int unsigned TO_CYC = 40000000
) (
  input  logic clk,
  input  logic srst,
  input  logic fault,
  output logic done
);
  localparam int unsigned TW = cwidth(TO_CYC);
  localparam logic [TW-1:0] TO_V = TW'(TO_CYC);

  logic [TW-1:0] tcnt;

  // any fault restarts the count from zero
  always_ff @(posedge clk) begin
    if (srst || fault) tcnt <= '0;
    else if (!done)    tcnt <= tcnt + 1'b1;
  end

  assign done = (tcnt == TO_V);
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 200,
  parameter int unsigned TIMEOUT_US = 200000,
  parameter int unsigned MR_QUAL_US = 25,
  parameter int unsigned MR_DLY_US  = 12
) (
  input  logic clk,
  input  logic test_rst,
  input  logic supply_ok,
  input  logic lowline_flag,
  input  logic pfail_flag,
  input  logic mr_n,
  output logic rst_n,
  output logic lowline_n,
  output logic pfail_n
);
  localparam int unsigned TO_CYC   = us2cyc(TIMEOUT_US, CYC_PER_US);
  localparam int unsigned QUAL_CYC = us2cyc(MR_QUAL_US, CYC_PER_US);
  localparam int unsigned DLY_CYC  = us2cyc(MR_DLY_US, CYC_PER_US);

  logic [NFLAG-1:0] raw, synced;
  logic sup_s, ll_s, pf_s, mr_s;
  logic qual_hit, fire, mr_act, fault, tmr_done;
  logic rst_n_q, lowline_n_q, pfail_n_q;

  assign raw = {mr_n, pfail_flag, lowline_flag, supply_ok};

  sup_sync #(.W(NFLAG), .RST_VAL(FLAG_RST)) u_sync (
    .clk(clk), .srst(test_rst), .d(raw), .q(synced)
  );

  assign sup_s = synced[FL_SUP];
  assign ll_s  = synced[FL_LL];
  assign pf_s  = synced[FL_PF];
  assign mr_s  = synced[FL_MR];

  sup_mr_qual #(.QUAL_CYC(QUAL_CYC), .DLY_CYC(DLY_CYC)) u_mr (
    .clk(clk), .srst(test_rst), .mr_s(mr_s),
    .qual_hit(qual_hit), .fire(fire), .mr_act(mr_act)
  );

  assign fault = !sup_s || mr_act;

  sup_rel_timer #(.TO_CYC(TO_CYC)) u_tmr (
    .clk(clk), .srst(test_rst), .fault(fault), .done(tmr_done)
  );

  always_ff @(posedge clk) begin
    if (test_rst) begin
      rst_n_q     <= 1'b0;
      lowline_n_q <= 1'b0;
      pfail_n_q   <= 1'b0;
    end else begin
      rst_n_q     <= !fault && tmr_done;
      lowline_n_q <= !ll_s;
      pfail_n_q   <= !pf_s;
    end
  end

  assign rst_n     = rst_n_q;
  assign lowline_n = lowline_n_q;
  assign pfail_n   = pfail_n_q;
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk (
  input logic clk,
  input logic test_rst,
  input logic sup_s,
  input logic mr_s,
  input logic ll_s,
  input logic pf_s,
  input logic qual_hit,
  input logic mr_act,
  input logic fault,
  input logic tmr_done,
  input logic rst_n,
  input logic lowline_n,
  input logic pfail_n
);
  a_r1_supply_forces_reset: assert property (@(posedge clk) disable iff (test_rst)
    !sup_s |=> !rst_n);

  a_r2_release_after_timeout: assert property (@(posedge clk) disable iff (test_rst)
    $rose(rst_n) |-> ($past(tmr_done) && !$past(fault)));

  a_r3_fault_restarts_timer: assert property (@(posedge clk) disable iff (test_rst)
    fault |=> !tmr_done);

  a_r4_qual_needs_held_low: assert property (@(posedge clk) disable iff (test_rst)
    qual_hit |-> (!mr_s && $past(!mr_s)));

  a_r5_manual_forces_reset: assert property (@(posedge clk) disable iff (test_rst)
    mr_act |=> !rst_n);

  a_r7_pfail_follows: assert property (@(posedge clk) disable iff (test_rst)
    1'b1 |=> (pfail_n == !$past(pf_s)));

  a_r8_lowline_follows: assert property (@(posedge clk) disable iff (test_rst)
    1'b1 |=> (lowline_n == !$past(ll_s)));
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk u_chk (
  .clk(clk), .test_rst(test_rst), .sup_s(sup_s), .mr_s(mr_s), .ll_s(ll_s),
  .pf_s(pf_s), .qual_hit(qual_hit), .mr_act(mr_act), .fault(fault),
  .tmr_done(tmr_done), .rst_n(rst_n), .lowline_n(lowline_n), .pfail_n(pfail_n)
);

// File: tb/sup_reset_ctrl_test.sv
`timescale 1ns/1ps
module sup_reset_ctrl_test;
  localparam int unsigned CPU  = 2;
  localparam int unsigned T_US = 40;
  localparam int unsigned Q_US = 4;
  localparam int unsigned D_US = 3;

  function automatic int cyc(input int us);
    return us * CPU;
  endfunction

  localparam int TO   = T_US * CPU;
  localparam int QUAL = Q_US * CPU;
  localparam int DLY  = D_US * CPU;

  logic clk = 1'b0;
  logic test_rst, supply_ok, lowline_flag, pfail_flag, mr_n;
  logic rst_n, lowline_n, pfail_n;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sup_reset_ctrl #(.CYC_PER_US(CPU), .TIMEOUT_US(T_US), .MR_QUAL_US(Q_US), .MR_DLY_US(D_US)) uut (
    .clk(clk), .test_rst(test_rst), .supply_ok(supply_ok), .lowline_flag(lowline_flag),
    .pfail_flag(pfail_flag), .mr_n(mr_n), .rst_n(rst_n), .lowline_n(lowline_n), .pfail_n(pfail_n)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // rst_n low window for a manual pulse of L cycles, edges counted from the drive
  function automatic bit exp_low(input int n, input int L);
    int f, c;
    f = cyc(Q_US) + cyc(D_US) + 3;
    if (L <= cyc(Q_US)) return 1'b0;
    c = (L + 3 > f + 1) ? L + 3 : f + 1;
    return (n >= f + 1) && (n <= c + cyc(T_US));
  endfunction

  function automatic int last_edge(input int L);
    int f, c;
    f = QUAL + DLY + 3;
    if (L <= QUAL) return f + 5;
    c = (L + 3 > f + 1) ? L + 3 : f + 1;
    return c + TO;
  endfunction

  // release check: still low after edge n-1, high after edge n
  task automatic expect_release(input string req, input int n);
    step(n - 1);
    chk(req, "rst_n one edge before release", int'(rst_n), 0);
    step(1);
    chk(req, "rst_n at release edge", int'(rst_n), 1);
  endtask

  task automatic run_trial(input int L, input string req);
    int bad_rst, bad_pf, bad_ll, first_bad, nmax;
    bit ph0, ph1, ph2, lh0, lh1, lh2, pnew, lnew;
    bad_rst = 0; bad_pf = 0; bad_ll = 0; first_bad = -1;
    ph0 = 0; ph1 = 0; ph2 = 0; lh0 = 0; lh1 = 0; lh2 = 0;
    nmax = last_edge(L) + 4;
    mr_n = 1'b0;
    for (int n = 1; n <= nmax; n++) begin
      step(1);
      if (rst_n !== !exp_low(n, L)) begin
        bad_rst++;
        if (first_bad < 0) first_bad = n;
      end
      if (pfail_n !== !ph2) bad_pf++;
      if (lowline_n !== !lh2) bad_ll++;
      ph2 = ph1; ph1 = ph0; pnew = 1'($urandom_range(1, 0)); ph0 = pnew; pfail_flag = pnew;
      lh2 = lh1; lh1 = lh0; lnew = 1'($urandom_range(1, 0)); lh0 = lnew; lowline_flag = lnew;
      if (n == L) mr_n = 1'b1;
    end
    if (bad_rst != 0) $display("  trial L=%0d first mismatch at edge %0d", L, first_bad);
    chk(req, "rst_n window mismatches", bad_rst, 0);
    chk("R7", "pfail_n mismatches", bad_pf, 0);
    chk("R8", "lowline_n mismatches", bad_ll, 0);
    pfail_flag = 1'b0;
    lowline_flag = 1'b0;
    step(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    test_rst = 1'b1; supply_ok = 1'b1; lowline_flag = 1'b0; pfail_flag = 1'b0; mr_n = 1'b1;
    step(4);
    chk("R9", "rst_n in test reset", int'(rst_n), 0);
    chk("R9", "lowline_n in test reset", int'(lowline_n), 0);
    chk("R9", "pfail_n in test reset", int'(pfail_n), 0);
    test_rst = 1'b0;
    expect_release("R9", TO + 3);
    chk("R8", "lowline_n idle", int'(lowline_n), 1);

    // R7 and R8: warnings follow their flags, reset untouched
    pfail_flag = 1'b1;
    step(2);
    chk("R7", "pfail_n before latency", int'(pfail_n), 1);
    step(1);
    chk("R7", "pfail_n after 3 edges", int'(pfail_n), 0);
    chk("R7", "rst_n unaffected by power fail", int'(rst_n), 1);
    lowline_flag = 1'b1;
    step(2);
    chk("R8", "lowline_n before latency", int'(lowline_n), 1);
    step(1);
    chk("R8", "lowline_n after 3 edges", int'(lowline_n), 0);
    chk("R8", "rst_n unaffected by low line", int'(rst_n), 1);
    pfail_flag = 1'b0; lowline_flag = 1'b0;
    step(3);
    chk("R7", "pfail_n cleared", int'(pfail_n), 1);
    chk("R8", "lowline_n cleared", int'(lowline_n), 1);

    // R1: supply loss
    supply_ok = 1'b0;
    step(2);
    chk("R1", "rst_n before supply latency", int'(rst_n), 1);
    step(1);
    chk("R1", "rst_n after supply loss", int'(rst_n), 0);
    step(TO + 20);
    chk("R1", "rst_n held while supply bad", int'(rst_n), 0);
    supply_ok = 1'b1;
    expect_release("R2", TO + 3);

    // R3: brownout during the time-out
    supply_ok = 1'b0;
    step(5);
    supply_ok = 1'b1;
    step(TO / 2);
    chk("R3", "rst_n mid time-out", int'(rst_n), 0);
    supply_ok = 1'b0;
    step(4);
    supply_ok = 1'b1;
    expect_release("R3", TO + 3);

    // manual reset corners
    run_trial(1, "R4");
    run_trial(QUAL, "R4");
    run_trial(QUAL + 1, "R5");
    run_trial(QUAL + DLY + 1, "R5");
    run_trial(QUAL + DLY + 2, "R6");
    run_trial(40, "R6");

    // R6 held button: release TO+4 edges after mr_n rises
    mr_n = 1'b0;
    step(QUAL + DLY + 10);
    chk("R6", "rst_n while held", int'(rst_n), 0);
    mr_n = 1'b1;
    expect_release("R6", TO + 4);

    for (int t = 0; t < 12; t++) begin
      run_trial($urandom_range(QUAL + DLY + 12, 1), "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule